// File: doc/BRIEF.md
# SPI Master Controller with Buffered Data Register

This block is an SPI master with a small register window. Software sets up the line format in a control register. It then writes words into a data register. Each word waits in a one-entry transmit holding buffer until the shift engine takes it. The engine drives the serial clock and the serial output, and it samples the serial input. When a frame ends, the received word moves into a one-entry receive buffer, where software reads it.

A status register reports whether the transmit buffer is empty, whether the receive buffer holds a word, whether a frame is on the line, and whether a received word was lost. Software normally writes a word, waits until the transmit buffer is empty and the engine is idle, and then reads the received word. To keep the line streaming, software can write the next word while the current frame is still shifting. Slave select is kept outside the block. An internal select level, set by a control bit, gates master operation.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x0001 (transmit-empty only), SCK is low and MOSI is low.
- R2: Address map: 0 is control, 1 is status, 2 is data. Control bits: [0] enable, [1] master, [4:2] DIV, [5] CPOL, [6] CPHA, [7] LSB-first, [8] 16-bit frame, [9] software select, [10] select level. Status bits: [0] transmit-empty, [1] receive-full, [2] busy, [3] overrun. A control write is read back unchanged when no other rule overrides it.
- R3: One SCK half period lasts 2^DIV clock cycles. The SCK frequency is therefore clk / 2^(DIV+1). SCK edges in a frame are evenly spaced.
- R4: When idle, SCK sits at CPOL. With CPHA=0, data is sampled on the first edge of each bit and driven on the second edge. With CPHA=1, data is driven on the first edge and sampled on the second.
- R5: With LSB-first clear, the most significant bit of the frame goes out and comes in first. With it set, the least significant bit goes first.
- R6: With the 16-bit bit clear, frames carry 8 bits. Only bits [7:0] of a data write are sent, and a data read returns 0 in bits [15:8].
- R7: A data write clears transmit-empty. The word moves into the shifter, transmit-empty sets again, and busy stays high until the frame's last SCK edge.
- R8: At the end of a frame, the received word enters the receive buffer and receive-full sets. A data read clears receive-full.
- R9: If transmit-empty is 0 when a frame ends, the next frame starts with no idle SCK half period between the two frames.
- R10: A frame that ends while receive-full is set raises overrun and is discarded; the buffer keeps its old word. Overrun clears only on a status read that follows a data read. A status read alone does not clear it.
- R11: With software select set and the select level low, setting master mode is a mode fault. The fault clears both enable and master.
- R12: While enable is 1, control writes do not change DIV, CPOL, CPHA, LSB-first or the 16-bit bit.
- R13: A frame starts only while enable and master are both 1. Until then, a written word waits with transmit-empty at 0 and SCK does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The hardest states to reach are the ones that depend on when software acts relative to the end of a frame. A back-to-back pair needs the second word written after the first has left the holding buffer but before its last edge. An overrun needs a second frame to finish while the first word is still unread. The stimulus drives these states only through status polling. It writes the second word as soon as transmit-empty returns, and it reads the first word during the second frame. For the overrun case, it deliberately skips that read. A bus-functional slave on the serial pins, clocked by SCK edges alone, captures every frame and returns its own pattern. Each frame is then compared against a scoreboard of queued words.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W = 16;
  localparam int HALF_W = WORD_W / 2;
  localparam int DIV_W  = 3;
  localparam int ADDR_W = 2;
  localparam int EDGE_W = $clog2(2 * WORD_W);
  localparam int CNT_W  = (1 << DIV_W) - 1;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic             sslvl;
    logic             swsel;
    logic             wide;
    logic             lsbf;
    logic             cpha;
    logic             cpol;
    logic [DIV_W-1:0] div;
    logic             mstr;
    logic             en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/spim_baud.sv
module spim_baud
  import spim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   half_len;
  logic [CNT_W-1:0] half_m1;
  logic             cnt_en;

  assign half_len = {{CNT_W{1'b0}}, 1'b1} << div;
  assign half_m1  = CNT_W'(half_len - 1'b1);
  assign tick     = run && (cnt_q == half_m1);
  assign cnt_en   = run || restart;

  always_comb begin
    cnt_d = cnt_q;
    if (restart || tick) cnt_d = '0;
    else if (run)        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // half period longer than one cycle: ticks never come back to back
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && div != '0) |=> !tick);
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic [WORD_W-1:0] word,
  input  logic              tick,
  input  logic              cpha,
  input  logic              lsbf,
  input  logic              wide,
  input  logic              miso,
  output logic              run,
  output logic              take,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              phase,
  output logic              mosi
);
  logic              run_q, run_d;
  logic [EDGE_W-1:0] edge_q, edge_d, last_edge;
  logic [WORD_W-1:0] tx_q, tx_d, rx_q, rx_d, src;
  logic              mosi_q, mosi_d, phase_q, phase_d;
  logic              leading, last, load, emit, samp, head;

  assign last_edge = wide ? EDGE_W'(2 * WORD_W - 1) : EDGE_W'(2 * HALF_W - 1);
  assign leading   = !edge_q[0];
  assign last      = run_q && tick && (edge_q == last_edge);
  assign load      = start_ok && (!run_q || last);
  assign emit      = (load && !cpha) ||
                     (run_q && tick && !last && (cpha ? leading : !leading));
  assign samp      = run_q && tick && (cpha ? !leading : leading);
  assign src       = load ? word : tx_q;
  assign head      = lsbf ? src[0] : (wide ? src[WORD_W-1] : src[HALF_W-1]);

  always_comb begin
    run_d   = run_q;
    edge_d  = edge_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    mosi_d  = mosi_q;
    phase_d = phase_q;
    if (samp)
      rx_d = lsbf ? {miso, rx_q[WORD_W-1:1]} : {rx_q[WORD_W-2:0], miso};
    if (run_q && tick) begin
      phase_d = !phase_q;
      edge_d  = edge_q + 1'b1;
    end
    if (last) run_d = 1'b0;
    if (emit) begin
      mosi_d = head;
      tx_d   = lsbf ? (src >> 1) : (src << 1);
    end else if (load) begin
      tx_d = word;
    end
    if (load) begin
      run_d  = 1'b1;
      edge_d = '0;
      rx_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      edge_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      mosi_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      phase_q <= phase_d;
      mosi_q  <= mosi_d;
      if (run_q || load) begin
        edge_q <= edge_d;
        tx_q   <= tx_d;
        rx_q   <= rx_d;
      end
    end
  end

  // final word includes the sample taken on the closing edge
  always_comb begin
    logic [WORD_W-1:0] fin;
    fin = lsbf ? {miso, rx_q[WORD_W-1:1]} : {rx_q[WORD_W-2:0], miso};
    if (!samp) fin = rx_q;
    if (wide)      rx_word = fin;
    else if (lsbf) rx_word = {{HALF_W{1'b0}}, fin[WORD_W-1 -: HALF_W]};
    else           rx_word = {{HALF_W{1'b0}}, fin[HALF_W-1:0]};
  end

  assign run   = run_q;
  assign take  = load;
  assign done  = last;
  assign phase = phase_q;
  assign mosi  = mosi_q;

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !phase_q);
  assert_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (last && load) |=> (run_q && edge_q == '0));
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output ctrl_t             ctrl,
  output logic [WORD_W-1:0] tx_word,
  output logic              tx_full,
  input  logic              take,
  input  logic              done,
  input  logic [WORD_W-1:0] done_word,
  input  logic              busy
);
  ctrl_t             ctrl_q, ctrl_d, wr_val;
  logic [WORD_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic              full_q, full_d, rxne_q, rxne_d, ovr_q, ovr_d, arm_q, arm_d;
  logic              wr_ctrl, wr_data, rd_data, rd_stat, tx_en, rx_en;

  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
  assign wr_data = bus_sel && bus_wr && (bus_addr == A_DATA);
  assign rd_data = bus_sel && !bus_wr && (bus_addr == A_DATA);
  assign rd_stat = bus_sel && !bus_wr && (bus_addr == A_STAT);
  assign wr_val  = ctrl_t'(bus_wdata[CTRL_W-1:0]);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.en    = wr_val.en;
      ctrl_d.mstr  = wr_val.mstr;
      ctrl_d.swsel = wr_val.swsel;
      ctrl_d.sslvl = wr_val.sslvl;
      if (!ctrl_q.en) begin
        ctrl_d.div  = wr_val.div;
        ctrl_d.cpol = wr_val.cpol;
        ctrl_d.cpha = wr_val.cpha;
        ctrl_d.lsbf = wr_val.lsbf;
        ctrl_d.wide = wr_val.wide;
      end
    end
    if (ctrl_d.mstr && ctrl_d.swsel && !ctrl_d.sslvl) begin
      ctrl_d.en   = 1'b0;
      ctrl_d.mstr = 1'b0;
    end
  end

  always_comb begin
    tx_d   = tx_q;
    full_d = full_q;
    if (wr_data) begin
      tx_d   = bus_wdata;
      full_d = 1'b1;
    end else if (take) begin
      full_d = 1'b0;
    end
  end
  assign tx_en = wr_data;

  always_comb begin
    rx_d   = rx_q;
    rxne_d = rxne_q;
    ovr_d  = ovr_q;
    arm_d  = arm_q;
    rx_en  = 1'b0;
    if (rd_data) begin
      rxne_d = 1'b0;
      if (ovr_q) arm_d = 1'b1;
    end
    if (rd_stat && arm_q) begin
      ovr_d = 1'b0;
      arm_d = 1'b0;
    end
    if (done) begin
      if (!rxne_q || rd_data) begin
        rx_d   = done_word;
        rxne_d = 1'b1;
        rx_en  = 1'b1;
      end else begin
        ovr_d = 1'b1;
        arm_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      full_q <= 1'b0;
      rxne_q <= 1'b0;
      ovr_q  <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      full_q <= full_d;
      rxne_q <= rxne_d;
      ovr_q  <= ovr_d;
      arm_q  <= arm_d;
      if (tx_en) tx_q <= tx_d;
      if (rx_en) rx_q <= rx_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = WORD_W'(ctrl_q);
      A_STAT:  bus_rdata = {{(WORD_W-4){1'b0}}, ovr_q, busy, rxne_q, !full_q};
      A_DATA:  bus_rdata = ctrl_q.wide ? rx_q : {{HALF_W{1'b0}}, rx_q[HALF_W-1:0]};
      default: bus_rdata = '0;
    endcase
  end

  assign ctrl    = ctrl_q;
  assign tx_word = tx_q;
  assign tx_full = full_q;

  assert_tx_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> full_q);
  assert_rx_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rxne_q) |=> (rxne_q && rx_q == $past(done_word)));
  assert_rx_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done) |=> !rxne_q);
  assert_rx_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rxne_q && !rd_data) |=> (ovr_q && $stable(rx_q)));
  assert_mode_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[1] && bus_wdata[9] && !bus_wdata[10]) |=> (!ctrl_q.en && !ctrl_q.mstr));
  assert_fmt_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctrl_q.en) |=> ($stable(ctrl_q.div) && $stable(ctrl_q.wide) && $stable(ctrl_q.cpha)));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  ctrl_t             ctrl;
  logic [WORD_W-1:0] tx_word, rx_word;
  logic              tx_full, start_ok, run, take, done, tick, phase;

  assign start_ok = tx_full && ctrl.en && ctrl.mstr;

  spim_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ctrl      (ctrl),
    .tx_word   (tx_word),
    .tx_full   (tx_full),
    .take      (take),
    .done      (done),
    .done_word (rx_word),
    .busy      (run)
  );

  spim_baud u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (take),
    .div     (ctrl.div),
    .tick    (tick)
  );

  spim_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ok (start_ok),
    .word     (tx_word),
    .tick     (tick),
    .cpha     (ctrl.cpha),
    .lsbf     (ctrl.lsbf),
    .wide     (ctrl.wide),
    .miso     (spi_miso),
    .run      (run),
    .take     (take),
    .done     (done),
    .rx_word  (rx_word),
    .phase    (phase),
    .mosi     (spi_mosi)
  );

  assign spi_sck = ctrl.cpol ^ phase;

  assert_start_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (ctrl.en && ctrl.mstr && tx_full));
  assert_quiet_line_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !take) |=> (spi_sck == ctrl.cpol));
endmodule

// File: tb/test_spim_ctrl.sv
module test_spim_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] AC = 2'd0, AS = 2'd1, AD = 2'd2;
  localparam logic [15:0] EN = 16'h0001, MS = 16'h0002, SWS = 16'h0200, LVL = 16'h0400;

  logic clk, rst_n, bus_sel, bus_wr, spi_sck, spi_mosi, miso_r;
  logic [1:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;

  typedef struct { logic [15:0] tx; logic [15:0] slv; } item_t;
  item_t sb_q[$];
  int n_cmp = 0, n_bad = 0;
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_lsbf = 0, cfg_wide = 0, mon_on = 0;
  int cfg_div = 0, bit_j = 0, tog_cnt = 0;
  logic [15:0] cap = 0;
  time t_first = 0, t_last = 0;

  spim_ctrl i_spim_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(miso_r)
  );

  initial clk = 0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int nbits();
    return cfg_wide ? 16 : 8;
  endfunction
  function automatic logic [15:0] wmask(logic [15:0] w);
    return cfg_wide ? w : {8'h00, w[7:0]};
  endfunction
  function automatic logic slv_bit(logic [15:0] w, int j);
    if (j >= nbits()) return 1'b0;
    return cfg_lsbf ? w[j] : w[nbits() - 1 - j];
  endfunction
  function automatic logic [15:0] ctrl_word(int div, logic cp, logic ch, logic lf, logic wd);
    return 16'(div << 2) | {10'd0, ch, cp, 5'd0} | {7'd0, wd, lf, 7'd0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // slave model and scoreboard monitor on the serial pins
  always @(spi_sck) begin
    if (rst_n && mon_on) begin
      logic lead;
      lead = (spi_sck != cfg_cpol);
      tog_cnt++;
      if (tog_cnt == 1) t_first = $time;
      t_last = $time;
      if (cfg_cpha ? !lead : lead) begin
        if (sb_q.size() == 0) begin
          check("R13 unexpected frame", 1, 0);
        end else begin
          cap[cfg_lsbf ? bit_j : nbits() - 1 - bit_j] = spi_mosi;
          bit_j++;
          if (bit_j == nbits()) begin
            check("R5 mosi word (R4 mode)", cap, wmask(sb_q[0].tx));
            void'(sb_q.pop_front());
            bit_j = 0;
            cap = 0;
          end
        end
        miso_r = (sb_q.size() > 0) ? slv_bit(sb_q[0].slv, bit_j) : 1'b0;
      end
    end
  end

  task automatic bus_write(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic wait_stat(logic [15:0] m, logic [15:0] v);
    logic [15:0] s;
    for (int k = 0; k < 12000; k++) begin
      bus_read(AS, s);
      if ((s & m) == v) return;
    end
    check("R7 status wait timeout", 32'(s), 32'(v));
  endtask

  task automatic push(logic [15:0] tx, logic [15:0] slv);
    item_t it;
    it.tx = tx; it.slv = slv;
    sb_q.push_back(it);
    if (sb_q.size() == 1) miso_r = slv_bit(slv, bit_j);
  endtask

  task automatic configure(int div, logic cp, logic ch, logic lf, logic wd);
    logic [15:0] f, r;
    mon_on = 0;
    bus_write(AC, 16'h0000);
    cfg_div = div; cfg_cpol = cp; cfg_cpha = ch; cfg_lsbf = lf; cfg_wide = wd;
    f = ctrl_word(div, cp, ch, lf, wd);
    bus_write(AC, f);
    bus_write(AC, f | EN | MS | SWS | LVL);
    bus_read(AC, r);
    check("R2 control readback", r, f | EN | MS | SWS | LVL);
    bit_j = 0; cap = 0; miso_r = 0;
    repeat (2) @(posedge clk);
    mon_on = 1;
  endtask

  task automatic one_frame(logic [15:0] tx, logic [15:0] slv);
    logic [15:0] s, d;
    int half;
    half = 1 << cfg_div;
    tog_cnt = 0;
    push(tx, slv);
    bus_write(AD, tx);
    wait_stat(16'h0005, 16'h0001);
    check("R3 frame span", 32'(t_last - t_first), 32'((2 * nbits() - 1) * half * CLK_PERIOD));
    check("R4 idle sck", 32'(spi_sck), 32'(cfg_cpol));
    bus_read(AS, s);
    check("R8 receive-full set", 32'(s[1]), 1);
    bus_read(AD, d);
    check("R8 rx word", d, wmask(slv));
    if (!cfg_wide) check("R6 upper byte zero", 32'(d[15:8]), 0);
    bus_read(AS, s);
    check("R8 receive-full cleared", 32'(s[1]), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    logic [15:0] r, s;
    miso_r = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    bus_read(AC, r); check("R1 control after reset", r, 0);
    bus_read(AS, r); check("R1 status after reset", r, 16'h0001);
    check("R1 sck low", 32'(spi_sck), 0);
    check("R1 mosi low", 32'(spi_mosi), 0);

    // R13 word waits while disabled, then starts when enabled
    mon_on = 1; tog_cnt = 0;
    push(16'h005A, 16'h00C6);
    bus_write(AD, 16'h005A);
    repeat (60) @(posedge clk);
    bus_read(AS, s);
    check("R13 held word keeps transmit-empty low", s, 16'h0000);
    check("R13 no sck while disabled", tog_cnt, 0);
    bus_write(AC, EN | MS | SWS | LVL);
    wait_stat(16'h0005, 16'h0001);
    bus_read(AD, r); check("R13 frame after enable", r, 16'h00C6);

    // R3 R4 R5 R6: all modes, both orders, both widths
    for (int m = 0; m < 4; m++) begin
      for (int l = 0; l < 2; l++) begin
        configure(m, m[1], m[0], l[0], ((m + l) % 2) == 1);
        one_frame(16'hA5C3 ^ 16'(16'h1357 * (2 * m + l + 1)), 16'h3C96 ^ 16'(16'h0B1D * (m + 3 * l + 1)));
      end
    end
    configure(7, 1, 0, 0, 1);
    one_frame(16'h8001, 16'h7FFE);
    configure(1, 0, 0, 0, 0);
    one_frame(16'hA5C3, 16'h9E3C);

    // R12 format locked while enabled
    bus_write(AC, ctrl_word(5, 0, 0, 0, 0) | EN | MS | SWS | LVL);
    bus_read(AC, r);
    check("R12 divider unchanged", 32'(r[4:2]), 1);
    one_frame(16'h0081, 16'h0042);

    // R11 mode fault
    mon_on = 0;
    bus_write(AC, ctrl_word(1, 0, 0, 0, 0) | EN | MS | SWS);
    bus_read(AC, r);
    check("R11 fault clears enable and master", r, ctrl_word(1, 0, 0, 0, 0) | SWS);
    mon_on = 1; tog_cnt = 0;
    push(16'h00E7, 16'h0018);
    bus_write(AD, 16'h00E7);
    repeat (40) @(posedge clk);
    bus_read(AS, s);
    check("R11 no transfer after fault", s, 16'h0000);
    check("R11 no sck after fault", tog_cnt, 0);
    bus_write(AC, ctrl_word(1, 0, 0, 0, 0) | EN | MS | SWS | LVL);
    wait_stat(16'h0005, 16'h0001);
    bus_read(AD, r); check("R11 frame after recovery", r, 16'h0018);

    // R9 back-to-back frames in mode 3
    configure(2, 1, 1, 0, 0);
    tog_cnt = 0;
    push(16'h00D2, 16'h004B);
    bus_write(AD, 16'h00D2);
    wait_stat(16'h0001, 16'h0001);
    push(16'h0039, 16'h00F0);
    bus_write(AD, 16'h0039);
    wait_stat(16'h0002, 16'h0002);
    bus_read(AD, r); check("R9 first word", r, 16'h004B);
    wait_stat(16'h0005, 16'h0001);
    bus_read(AD, r); check("R9 second word", r, 16'h00F0);
    check("R9 no gap between frames", 32'(t_last - t_first), 32'((4 * 8 - 1) * 4 * CLK_PERIOD));

    // R10 overrun
    configure(0, 0, 1, 1, 1);
    push(16'h1234, 16'hBEEF);
    bus_write(AD, 16'h1234);
    wait_stat(16'h0005, 16'h0001);
    push(16'h4321, 16'h0DD0);
    bus_write(AD, 16'h4321);
    wait_stat(16'h0009, 16'h0009);
    wait_stat(16'h0005, 16'h0001);
    bus_read(AS, s); check("R10 overrun raised", s, 16'h000B);
    bus_read(AS, s); check("R10 status read alone keeps overrun", s, 16'h000B);
    bus_read(AD, r); check("R10 old word kept", r, 16'hBEEF);
    bus_read(AS, s); check("R10 overrun still shown", s, 16'h0009);
    bus_read(AS, s); check("R10 overrun cleared", s, 16'h0001);

    repeat (5) @(posedge clk);
    check("R7 scoreboard drained", sb_q.size(), 0);
    report();
    $finish;
  end
endmodule